// File: doc/BRIEF.md
# Real-Time Clock Alarm and Periodic Interrupt Unit

This unit raises interrupts for a real-time clock. An external time counter supplies the current minute and hour as BCD bytes, together with single-cycle tick strobes at the half-second, second, minute, hour and day boundaries. Software reaches five small registers through a plain address/data port: an alarm minute, an alarm hour, an alarm control register, a status register and a periodic-rate selector.

The alarm fires when the stored minute and hour both equal the counter's minute and hour while the alarm enable bit is set. To arm it, software clears the enable bit, loads the alarm time, and sets the enable bit again. The periodic source fires on whichever tick strobe the selector names. Both sources pull one shared active-low interrupt line. Each source has its own status flag, so software can tell which one caused the request.

Top module: `rtc_irq_unit`

## Requirements
- R1: After reset, every register reads 0x00 and `irq_n` is high.
- R2: The alarm request goes active one clock after the inputs present a match, and `irq_n` falls at that point. A match means alarm enable (address 2, bit 0) is 1, `cur_min` equals the alarm minute (address 0) and `cur_hour` equals the alarm hour (address 1).
- R3: The minute and the hour must both match. A difference in either field keeps the alarm request inactive.
- R4: While alarm enable is 0, the alarm never pulls `irq_n` low. Writing enable to 0 during an active alarm releases the line on the next clock.
- R5: Status bit 0 (address 3) reads 1 exactly when the alarm request is driving the line low, which is the inverse of the alarm's contribution to the pin level.
- R6: An alarm request stays active for as long as the match lasts, and drops one clock after the time moves off the match. Writing status with bit 0 = 0 acknowledges the alarm and releases it for the rest of that match. A later match fires again.
- R7: Periodic select (address 4, bits 2:0) picks the tick that sets the periodic request: code 1 is `tick[0]` (half second), 2 is `tick[1]` (second), 3 is `tick[2]` (minute), 4 is `tick[3]` (hour) and 5 is `tick[4]` (day). Codes 0, 6 and 7 select no tick. The request goes active one clock after the selected tick.
- R8: Status bit 1 reads 1 while the periodic request is active. Writing status with bit 1 = 0 clears the request. Writing a 1 to either status bit has no effect. Ticks that are not selected are ignored. A selected tick in the same cycle as a clear leaves the request set.
- R9: `irq_n` is low whenever either request is active (the OR of the two requests). Both status flags can read 1 at the same time.
- R10: The alarm minute and alarm hour read back all 8 bits as written. The control register reads back bit 0 and the selector reads back bits 2:0; all other bits of these registers, and addresses 5 to 7, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cur_min | input | 8 | Current minute from the time counter, BCD |
| cur_hour | input | 8 | Current hour from the time counter, BCD |
| tick | input | 5 | One-cycle period strobes: half second, second, minute, hour, day |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| irq_n | output | 1 | Shared active-low interrupt request |

## Verification
The assertions assume that `cur_min`, `cur_hour` and `tick` change only between clock edges and hold steady across each edge. They also assume each tick is a single-cycle pulse and that `wr_en` is high for exactly one cycle per write. The bench drives every input on the falling edge, pulses each tick and each write for exactly one cycle, and samples outputs on the following falling edge. A time value stays on the inputs for at least a full clock, so each match lasts long enough to register.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
    localparam int DW    = 8;
    localparam int AW    = 3;
    localparam int SELW  = 3;
    localparam int NTICK = 5;

    localparam logic [AW-1:0] A_ALM_MIN  = 3'd0;
    localparam logic [AW-1:0] A_ALM_HOUR = 3'd1;
    localparam logic [AW-1:0] A_CTRL     = 3'd2;
    localparam logic [AW-1:0] A_STAT     = 3'd3;
    localparam logic [AW-1:0] A_PSEL     = 3'd4;

    localparam int EN_BIT  = 0;
    localparam int ALF_BIT = 0;
    localparam int PF_BIT  = 1;

    typedef struct packed {
        logic [DW-1:0] amin;
        logic [DW-1:0] ahour;
        logic          en;
        logic          ack;
        logic          req;
    } alm_state_t;

    typedef struct packed {
        logic [SELW-1:0] sel;
        logic            req;
    } per_state_t;
endpackage

// File: rtl/rtc_irq_alarm.sv
module rtc_irq_alarm
    import rtc_irq_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] cur_min,
    input  logic [DW-1:0] cur_hour,
    input  logic          wr_min,
    input  logic          wr_hour,
    input  logic          wr_ctrl,
    input  logic          wr_stat,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] alm_min,
    output logic [DW-1:0] alm_hour,
    output logic          alm_en,
    output logic          alm_req
);
    alm_state_t s_d, s_q;
    logic match;
    logic ack_wr;

    always_comb begin
        s_d    = s_q;
        match  = (cur_min == s_q.amin) && (cur_hour == s_q.ahour);
        ack_wr = wr_stat && !wdata[ALF_BIT];
        if (wr_min)  s_d.amin  = wdata;
        if (wr_hour) s_d.ahour = wdata;
        if (wr_ctrl) s_d.en    = wdata[EN_BIT];
        if (ack_wr && match) s_d.ack = 1'b1;
        if (!match || !s_d.en) s_d.ack = 1'b0;
        s_d.req = s_d.en && match && !s_d.ack;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign alm_min  = s_q.amin;
    assign alm_hour = s_q.ahour;
    assign alm_en   = s_q.en;
    assign alm_req  = s_q.req;

    // R2: an enabled, unacknowledged match with no register write becomes a request
    p_match_fires_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (match && s_q.en && !s_q.ack && !wr_stat && !wr_ctrl && !wr_min && !wr_hour)
        |=> alm_req);
    // R6 / R3: no request survives a cycle without a full match
    p_nomatch_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !match |=> !alm_req);
    // R4: writing enable low removes the request on the next clock
    p_disable_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !wdata[EN_BIT]) |=> !alm_req);
endmodule

// File: rtl/rtc_irq_periodic.sv
module rtc_irq_periodic
    import rtc_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NTICK-1:0] tick,
    input  logic             wr_sel,
    input  logic             wr_stat,
    input  logic [DW-1:0]    wdata,
    output logic [SELW-1:0]  per_sel,
    output logic             per_req
);
    per_state_t s_d, s_q;
    logic hit;
    logic clr;

    always_comb begin
        hit = 1'b0;
        for (int i = 0; i < NTICK; i++) begin
            if (s_q.sel == SELW'(i + 1) && tick[i]) hit = 1'b1;
        end
    end

    always_comb begin
        s_d = s_q;
        clr = wr_stat && !wdata[PF_BIT];
        if (wr_sel) s_d.sel = wdata[SELW-1:0];
        if (clr)    s_d.req = 1'b0;
        if (hit)    s_d.req = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign per_sel = s_q.sel;
    assign per_req = s_q.req;

    // R7: a selected tick always leaves the request set
    p_tick_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> per_req);
    // R8: only a clearing write can drop the request
    p_hold_until_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (per_req && !clr) |=> per_req);
endmodule

// File: rtl/rtc_irq_unit.sv
module rtc_irq_unit
    import rtc_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DW-1:0]    cur_min,
    input  logic [DW-1:0]    cur_hour,
    input  logic [NTICK-1:0] tick,
    input  logic             wr_en,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    output logic             irq_n
);
    logic [DW-1:0]   alm_min, alm_hour;
    logic            alm_en, alm_req;
    logic [SELW-1:0] per_sel;
    logic            per_req;
    logic            wr_min, wr_hour, wr_ctrl, wr_stat, wr_sel;

    assign wr_min  = wr_en && (addr == A_ALM_MIN);
    assign wr_hour = wr_en && (addr == A_ALM_HOUR);
    assign wr_ctrl = wr_en && (addr == A_CTRL);
    assign wr_stat = wr_en && (addr == A_STAT);
    assign wr_sel  = wr_en && (addr == A_PSEL);

    rtc_irq_alarm u_alarm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cur_min  (cur_min),
        .cur_hour (cur_hour),
        .wr_min   (wr_min),
        .wr_hour  (wr_hour),
        .wr_ctrl  (wr_ctrl),
        .wr_stat  (wr_stat),
        .wdata    (wdata),
        .alm_min  (alm_min),
        .alm_hour (alm_hour),
        .alm_en   (alm_en),
        .alm_req  (alm_req)
    );

    rtc_irq_periodic u_periodic (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .wr_sel  (wr_sel),
        .wr_stat (wr_stat),
        .wdata   (wdata),
        .per_sel (per_sel),
        .per_req (per_req)
    );

    always_comb begin
        rdata = '0;
        case (addr)
            A_ALM_MIN:  rdata = alm_min;
            A_ALM_HOUR: rdata = alm_hour;
            A_CTRL:     rdata[EN_BIT] = alm_en;
            A_STAT: begin
                rdata[ALF_BIT] = alm_req;
                rdata[PF_BIT]  = per_req;
            end
            A_PSEL:     rdata[SELW-1:0] = per_sel;
            default:    rdata = '0;
        endcase
    end

    assign irq_n = !(alm_req || per_req);

    // R5: with no periodic request, the alarm flag is the inverse of the pin
    p_flag_inverse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_STAT && !rdata[PF_BIT]) |-> (rdata[ALF_BIT] == !irq_n));
    // R9: a set periodic flag always holds the line low
    p_shared_line_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_STAT && rdata[PF_BIT]) |-> !irq_n);
endmodule

// File: tb/rtc_irq_unit_test.sv
module rtc_irq_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cur_min = 8'h00, cur_hour = 8'h00;
    logic [4:0] tick = '0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq_n;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    rtc_irq_unit uut (
        .clk(clk), .rst_n(rst_n), .cur_min(cur_min), .cur_hour(cur_hour),
        .tick(tick), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq_n(irq_n)
    );

    // {minute, hour, expected irq_n} against alarm 30:07, enabled
    localparam logic [16:0] VEC [8] = '{
        {8'h29, 8'h07, 1'b1},
        {8'h30, 8'h07, 1'b0},
        {8'h30, 8'h08, 1'b1},
        {8'h31, 8'h07, 1'b1},
        {8'h30, 8'h17, 1'b1},
        {8'h30, 8'h07, 1'b0},
        {8'h07, 8'h30, 1'b1},
        {8'h00, 8'h00, 1'b1}
    };

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic set_time(input logic [7:0] m, input logic [7:0] h);
        @(negedge clk);
        cur_min = m; cur_hour = h;
        @(negedge clk);
    endtask

    task automatic pulse(input int idx);
        @(negedge clk);
        tick[idx] = 1'b1;
        @(negedge clk);
        tick = '0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        #22 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            chk(v, 8'h00, "R1 reset register");
        end
        chk({7'd0, irq_n}, 8'h01, "R1 reset irq_n");

        // R10 readback
        wr(3'd0, 8'hA5); wr(3'd1, 8'h5A); wr(3'd2, 8'hFF); wr(3'd4, 8'hF8);
        rd(3'd0, v); chk(v, 8'hA5, "R10 alarm minute");
        rd(3'd1, v); chk(v, 8'h5A, "R10 alarm hour");
        rd(3'd2, v); chk(v, 8'h01, "R10 control");
        rd(3'd4, v); chk(v, 8'h00, "R10 selector width");
        rd(3'd6, v); chk(v, 8'h00, "R10 unused address");

        // arm: enable 0, load time, enable 1
        wr(3'd2, 8'h00); wr(3'd0, 8'h30); wr(3'd1, 8'h07); wr(3'd2, 8'h01);
        // R2 R3 table
        for (int i = 0; i < 8; i++) begin
            set_time(VEC[i][16:9], VEC[i][8:1]);
            chk({7'd0, irq_n}, {7'd0, VEC[i][0]}, "R2 R3 match table");
        end

        // R5 flag inverse; R6 hold through the match
        set_time(8'h30, 8'h07);
        rd(3'd3, v); chk(v, 8'h01, "R5 alarm flag set");
        repeat (5) @(negedge clk);
        chk({7'd0, irq_n}, 8'h00, "R6 request held during match");
        // R6 acknowledge with bit0=0, bit1=1 (no effect)
        wr(3'd3, 8'h02);
        chk({7'd0, irq_n}, 8'h01, "R6 ack releases");
        rd(3'd3, v); chk(v, 8'h00, "R5 flag clear after ack");
        set_time(8'h31, 8'h07);
        set_time(8'h30, 8'h07);
        chk({7'd0, irq_n}, 8'h00, "R6 next match fires");
        // R8 writing 1s to status has no effect
        wr(3'd3, 8'h03);
        chk({7'd0, irq_n}, 8'h00, "R8 write ones no effect");
        // R4 disable releases
        wr(3'd2, 8'h00);
        chk({7'd0, irq_n}, 8'h01, "R4 disable releases");
        set_time(8'h31, 8'h07); set_time(8'h30, 8'h07);
        chk({7'd0, irq_n}, 8'h01, "R4 disabled no fire");
        set_time(8'h00, 8'h00);

        // R7 each code picks its tick; R8 others ignored
        for (int c = 1; c <= 5; c++) begin
            wr(3'd4, 8'(c));
            for (int t = 0; t < 5; t++) begin
                if (t != c - 1) pulse(t);
            end
            chk({7'd0, irq_n}, 8'h01, "R8 unselected ticks ignored");
            pulse(c - 1);
            chk({7'd0, irq_n}, 8'h00, "R7 selected tick sets");
            rd(3'd3, v); chk(v, 8'h02, "R8 periodic flag");
            wr(3'd3, 8'h01);
            chk({7'd0, irq_n}, 8'h01, "R8 clear by writing 0");
        end
        wr(3'd4, 8'h00);
        for (int t = 0; t < 5; t++) pulse(t);
        chk({7'd0, irq_n}, 8'h01, "R7 code 0 off");
        wr(3'd4, 8'h07);
        for (int t = 0; t < 5; t++) pulse(t);
        chk({7'd0, irq_n}, 8'h01, "R7 code 7 off");

        // R8 tick coincides with clear: stays set
        wr(3'd4, 8'h02);
        @(negedge clk);
        wr_en = 1'b1; addr = 3'd3; wdata = 8'h00; tick[1] = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick = '0;
        rd(3'd3, v); chk(v, 8'h02, "R8 tick beats clear");

        // R9 both sources
        wr(3'd2, 8'h01);
        set_time(8'h30, 8'h07);
        rd(3'd3, v); chk(v, 8'h03, "R9 both flags");
        wr(3'd3, 8'h01);
        chk({7'd0, irq_n}, 8'h00, "R9 alarm alone holds line");
        wr(3'd3, 8'h02);
        chk({7'd0, irq_n}, 8'h01, "R9 both released");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule